// File: doc/BRIEF.md
# Swizzled Texel Address Generator

This block turns a texel coordinate pair into a byte offset inside a surface whose width and height are both powers of two and whose texels are stored in a swizzled (Morton-style) order. Each request carries the x and y coordinates, the base-two logarithms of the surface width and height, and a code that selects 1, 2 or 4 bytes per texel. The result is the byte offset of that texel from the start of the surface, together with a valid flag.

The interleaving applies only to a square region whose side is the smaller surface dimension, 2^k texels with k the smaller of the two logarithms. Within that square, the coordinate bits alternate, starting with x. Coordinate bits at position k and above are not interleaved. They are moved up by k positions and ORed in, so a long, narrow surface becomes a row of swizzled squares. The texel index is then scaled to bytes by a left shift.

The block is a two-stage pipeline that accepts one request on every clock cycle. The first stage interleaves and masks the bits. The second stage merges the high bits and applies the byte scaling. A typical use is in the address path of a texture or copy engine. That engine feeds one request per cycle and takes the offset two cycles later.

Top module: `swz_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first request has passed through, out_valid is 0 and offset is 0.
- R2: For every bit position i below k, bit i of x lands at bit 2i of the texel index and bit i of y lands at bit 2i+1. Interleaved bits at index position 2k and above are discarded.
- R3: k is the smaller of log2_w and log2_h. A value of k greater than the coordinate width (12 by default) is treated as that width.
- R4: The bits of x at positions k and above, shifted left by k, are ORed into the texel index. The same is done for the bits of y at positions k and above, also shifted left by k.
- R5: bpp_sel scales the index to bytes. Code 0 means 1 byte (offset = index). Code 1 means 2 bytes (index shifted left by 1). Codes 2 and 3 both mean 4 bytes (index shifted left by 2).
- R6: When k is 0, offset equals (x | y) scaled as in R5.
- R7: A request presented with in_valid high appears on offset with out_valid high exactly two clock edges later. A cycle with in_valid low gives out_valid low two edges later. Requests may arrive on every cycle.
- R8: While out_valid is low, offset keeps the last value it produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| x | input | COORD_W (12) | Texel column |
| y | input | COORD_W (12) | Texel row |
| log2_w | input | LOG_W (4) | Base-two logarithm of the surface width |
| log2_h | input | LOG_W (4) | Base-two logarithm of the surface height |
| bpp_sel | input | 2 | Bytes-per-texel code, see R5 |
| out_valid | output | 1 | Offset is valid this cycle |
| offset | output | 2*COORD_W+2 (26) | Byte offset of the texel |

## Verification
The checker's properties look two cycles back at x, y and bpp_sel. They therefore assume that those inputs are meaningful on every cycle in which in_valid is high. No request may be in flight across a reset. The alignment and zero-coordinate properties rely only on the scaling and the OR structure, so they hold for any surface size.

The bench drives every input once per cycle from a single task, at the falling edge, and never changes inputs in between. Reset is released only while the pipeline is empty. The log2 inputs are swept over their full 4-bit range, including values above 12, so the clamping in R3 is exercised as a legal case and not avoided.

// File: rtl/swz_pkg.sv
`timescale 1ns/1ps
package swz_pkg;

   // Largest byte scaling shift (4 bytes per texel).
   localparam int MAX_SHIFT = 2;
   localparam int SH_W      = 2;

   typedef enum logic [1:0] {
      BPP_ONE      = 2'd0,
      BPP_TWO      = 2'd1,
      BPP_FOUR     = 2'd2,
      BPP_FOUR_ALT = 2'd3
   } bpp_code_e;

   typedef logic [SH_W-1:0] shift_t;

   // Map a bytes-per-texel code onto a left-shift amount.
   function automatic shift_t shift_of(input logic [1:0] code);
      case (bpp_code_e'(code))
         BPP_ONE: return shift_t'(0);
         BPP_TWO: return shift_t'(1);
         default: return shift_t'(MAX_SHIFT);
      endcase
   endfunction

endpackage

// File: rtl/swz_interleave.sv
`timescale 1ns/1ps
// Stage 1: square size, bit interleave, low-part masking, high-part split.
module swz_interleave #(
   parameter int COORD_W = 12,
   parameter int LOG_W   = 4,
   parameter int KW      = $clog2(COORD_W + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [COORD_W-1:0]        x,
   input  logic [COORD_W-1:0]        y,
   input  logic [LOG_W-1:0]          log2_w,
   input  logic [LOG_W-1:0]          log2_h,
   input  logic [1:0]                bpp_sel,
   output logic                      s1_valid,
   output logic [2*COORD_W-1:0]      s1_low,
   output logic [COORD_W-1:0]        s1_xhi,
   output logic [COORD_W-1:0]        s1_yhi,
   output logic [KW-1:0]             s1_k,
   output swz_pkg::shift_t           s1_shift
);

   localparam int IL_W = 2 * COORD_W;

   logic [LOG_W-1:0]   k_min;
   logic [KW-1:0]      k_c;
   logic [KW:0]        k_twice;
   logic [IL_W-1:0]    il_raw;
   logic [IL_W-1:0]    il_keep;
   logic [COORD_W-1:0] xhi_c;
   logic [COORD_W-1:0] yhi_c;

   // Side of the swizzled square, clamped to the coordinate width.
   always_comb begin
      k_min = (log2_w < log2_h) ? log2_w : log2_h;
      if (32'(k_min) > COORD_W) k_c = KW'(COORD_W);
      else                      k_c = k_min[KW-1:0];
   end

   assign k_twice = {k_c, 1'b0};

   // Interleave: x to even positions, y to odd positions; split high parts.
   for (genvar i = 0; i < COORD_W; i++) begin : g_coord
      assign il_raw[2*i]   = x[i];
      assign il_raw[2*i+1] = y[i];
      assign xhi_c[i]      = x[i] & (KW'(i) >= k_c);
      assign yhi_c[i]      = y[i] & (KW'(i) >= k_c);
   end

   // Keep only the low 2k interleaved bits.
   for (genvar b = 0; b < IL_W; b++) begin : g_mask
      assign il_keep[b] = il_raw[b] & ((KW+1)'(b) < k_twice);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_low   <= '0;
         s1_xhi   <= '0;
         s1_yhi   <= '0;
         s1_k     <= '0;
         s1_shift <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_low   <= il_keep;
            s1_xhi   <= xhi_c;
            s1_yhi   <= yhi_c;
            s1_k     <= k_c;
            s1_shift <= swz_pkg::shift_of(bpp_sel);
         end
      end
   end

endmodule

// File: rtl/swz_merge.sv
`timescale 1ns/1ps
// Stage 2: merge high coordinate bits above the square and scale to bytes.
module swz_merge #(
   parameter int COORD_W = 12,
   parameter int KW      = $clog2(COORD_W + 1)
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       s1_valid,
   input  logic [2*COORD_W-1:0]                       s1_low,
   input  logic [COORD_W-1:0]                         s1_xhi,
   input  logic [COORD_W-1:0]                         s1_yhi,
   input  logic [KW-1:0]                              s1_k,
   input  swz_pkg::shift_t                            s1_shift,
   output logic                                       s2_valid,
   output logic [2*COORD_W+swz_pkg::MAX_SHIFT-1:0]    s2_offset
);

   localparam int IL_W  = 2 * COORD_W;
   localparam int OFS_W = IL_W + swz_pkg::MAX_SHIFT;
   localparam int N_SH  = swz_pkg::MAX_SHIFT + 1;

   logic [IL_W-1:0]  x_up;
   logic [IL_W-1:0]  y_up;
   logic [IL_W-1:0]  texel_idx;
   logic [OFS_W-1:0] cand [N_SH];
   logic [OFS_W-1:0] scaled;

   assign x_up      = {{COORD_W{1'b0}}, s1_xhi} << s1_k;
   assign y_up      = {{COORD_W{1'b0}}, s1_yhi} << s1_k;
   assign texel_idx = s1_low | x_up | y_up;

   // One candidate per supported byte scaling.
   for (genvar s = 0; s < N_SH; s++) begin : g_scale
      assign cand[s] = OFS_W'(texel_idx) << s;
   end

   always_comb begin
      scaled = '0;
      for (int s = 0; s < N_SH; s++) begin
         if (s1_shift == swz_pkg::SH_W'(s)) scaled = cand[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid  <= 1'b0;
         s2_offset <= '0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) s2_offset <= scaled;
      end
   end

endmodule

// File: rtl/swz_addr_gen.sv
`timescale 1ns/1ps
module swz_addr_gen #(
   parameter int COORD_W = 12,
   parameter int LOG_W   = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    in_valid,
   input  logic [COORD_W-1:0]                      x,
   input  logic [COORD_W-1:0]                      y,
   input  logic [LOG_W-1:0]                        log2_w,
   input  logic [LOG_W-1:0]                        log2_h,
   input  logic [1:0]                              bpp_sel,
   output logic                                    out_valid,
   output logic [2*COORD_W+swz_pkg::MAX_SHIFT-1:0] offset
);

   localparam int KW = $clog2(COORD_W + 1);

   if (COORD_W < 1 || COORD_W > 16) begin : g_bad_coord
      $error("swz_addr_gen: COORD_W out of range");
   end
   if (LOG_W < KW) begin : g_bad_log
      $error("swz_addr_gen: LOG_W too narrow to express COORD_W");
   end

   logic                      s1_valid;
   logic [2*COORD_W-1:0]      s1_low;
   logic [COORD_W-1:0]        s1_xhi;
   logic [COORD_W-1:0]        s1_yhi;
   logic [KW-1:0]             s1_k;
   swz_pkg::shift_t           s1_shift;

   swz_interleave #(.COORD_W(COORD_W), .LOG_W(LOG_W), .KW(KW)) u_stage1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .x        (x),
      .y        (y),
      .log2_w   (log2_w),
      .log2_h   (log2_h),
      .bpp_sel  (bpp_sel),
      .s1_valid (s1_valid),
      .s1_low   (s1_low),
      .s1_xhi   (s1_xhi),
      .s1_yhi   (s1_yhi),
      .s1_k     (s1_k),
      .s1_shift (s1_shift)
   );

   swz_merge #(.COORD_W(COORD_W), .KW(KW)) u_stage2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_low    (s1_low),
      .s1_xhi    (s1_xhi),
      .s1_yhi    (s1_yhi),
      .s1_k      (s1_k),
      .s1_shift  (s1_shift),
      .s2_valid  (out_valid),
      .s2_offset (offset)
   );

endmodule

// File: rtl/swz_addr_chk.sv
`timescale 1ns/1ps
module swz_addr_chk #(
   parameter int COORD_W = 12,
   parameter int LOG_W   = 4
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    in_valid,
   input logic [COORD_W-1:0]                      x,
   input logic [COORD_W-1:0]                      y,
   input logic [LOG_W-1:0]                        log2_w,
   input logic [LOG_W-1:0]                        log2_h,
   input logic [1:0]                              bpp_sel,
   input logic                                    out_valid,
   input logic [2*COORD_W+swz_pkg::MAX_SHIFT-1:0] offset
);

   // R7: a request emerges two edges later
   a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   // R7: an idle cycle emerges as idle two edges later
   a_r7_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   // R8: offset holds while no result is presented
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(offset));

   // R5: two- and four-byte texels give aligned offsets
   a_r5_align_two: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(bpp_sel, 2) != 2'd0) |-> (offset[0] == 1'b0));

   a_r5_align_four: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(bpp_sel, 2) >= 2'd2) |-> (offset[1:0] == 2'b00));

   // R6: the origin texel always sits at offset zero
   a_r6_origin_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(x, 2) == '0 && $past(y, 2) == '0) |-> (offset == '0));

   // R1: nothing valid leaves the block while reset is held
   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_idle: assert (out_valid == 1'b0);
   end

endmodule

bind swz_addr_gen swz_addr_chk #(.COORD_W(COORD_W), .LOG_W(LOG_W)) u_chk (.*);

// File: tb/sim_swz_addr_gen.sv
`timescale 1ns/1ps
module sim_swz_addr_gen;

   localparam int CW  = 12;
   localparam int LW  = 4;
   localparam int OW  = 2*CW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [CW-1:0] x = '0;
   logic [CW-1:0] y = '0;
   logic [LW-1:0] log2_w = '0;
   logic [LW-1:0] log2_h = '0;
   logic [1:0]    bpp_sel = '0;
   logic          out_valid;
   logic [OW-1:0] offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic          e1v = 1'b0, e2v = 1'b0;
   logic [OW-1:0] e1o = '0,   e2o = '0;
   string         e1t = "R1", e2t = "R1";
   logic [OW-1:0] last_o = '0;
   logic [31:0]   lfsr = 32'h1ACE_B00C;

   always #5 clk = ~clk;

   swz_addr_gen #(.COORD_W(CW), .LOG_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x), .y(y),
      .log2_w(log2_w), .log2_h(log2_h), .bpp_sel(bpp_sel),
      .out_valid(out_valid), .offset(offset)
   );

   // Arithmetic model of the swizzled byte offset.
   function automatic logic [OW-1:0] model(input logic [CW-1:0] xv, input logic [CW-1:0] yv,
                                           input int lw, input int lh, input int bp);
      int k;
      logic [63:0] il, hi, idx;
      k  = (lw < lh) ? lw : lh;
      if (k > CW) k = CW;
      il = 64'd0;
      for (int i = 0; i < CW; i++) begin
         il[2*i]   = xv[i];
         il[2*i+1] = yv[i];
      end
      il  = il % (64'd1 << (2*k));
      hi  = ((64'(xv) >> k) << (2*k)) | ((64'(yv) >> k) << (2*k));
      idx = il | hi;
      return OW'(idx * ((bp == 0) ? 1 : (bp == 1) ? 2 : 4));
   endfunction

   task automatic check_out(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [CW-1:0] xv, input logic [CW-1:0] yv,
                       input int lw, input int lh, input int bp, input string tag);
      check_out("R7", OW'(out_valid), OW'(e2v));
      check_out(e2t, offset, e2o);
      e2v = e1v; e2o = e1o; e2t = e1t;
      if (v) begin
         last_o = model(xv, yv, lw, lh, bp);
         e1t    = tag;
      end else begin
         e1t    = "R8";
      end
      e1v = v; e1o = last_o;
      in_valid = v; x = xv; y = yv;
      log2_w = LW'(lw); log2_h = LW'(lh); bpp_sel = 2'(bp);
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic string pick_tag(input int lw, input int lh, input int bp, input string base);
      int k;
      k = (lw < lh) ? lw : lh;
      if (k == 0)            return "R6";
      if (lw > CW || lh > CW) return "R3";
      if (bp == 3)           return "R5";
      return base;
   endfunction

   logic [CW-1:0] pat [6];

   initial begin
      pat[0] = 12'hFFF; pat[1] = 12'hA5C; pat[2] = 12'h123;
      pat[3] = 12'h800; pat[4] = 12'h000; pat[5] = 12'h5A5;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check_out("R1", OW'(out_valid), '0);   // R1 reset state
      check_out("R1", offset, '0);
      rst_n = 1'b1;

      // R2: exhaustive small coordinates over small squares
      for (int lw = 0; lw <= 4; lw++)
         for (int lh = 0; lh <= 4; lh++)
            for (int bp = 0; bp < 3; bp++)
               for (int xv = 0; xv < 16; xv++)
                  for (int yv = 0; yv < 16; yv++)
                     step(1'b1, CW'(xv), CW'(yv), lw, lh, bp, pick_tag(lw, lh, bp, "R2"));

      // R4: full-width coordinates, every log2 code incl. clamped ones (R3), all codes (R5)
      for (int lw = 0; lw < 16; lw++)
         for (int lh = 0; lh < 16; lh++)
            for (int bp = 0; bp < 4; bp++)
               for (int a = 0; a < 6; a++)
                  for (int b = 0; b < 6; b++)
                     step(1'b1, pat[a], pat[b], lw, lh, bp, pick_tag(lw, lh, bp, "R4"));

      // R7 and R8: gaps in the request stream, inputs still changing while idle
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[3] | lfsr[9], lfsr[15:4], lfsr[27:16], int'(lfsr[31:28]),
              int'(lfsr[3:0]), int'(lfsr[5:4]), "R7");
      end

      step(1'b0, '0, '0, 0, 0, 0, "R8");
      step(1'b0, '0, '0, 0, 0, 0, "R8");
      step(1'b0, 12'hFFF, 12'hFFF, 3, 3, 2, "R8");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule